// File: doc/BRIEF.md
# Flag-Setting Arithmetic and Logic Unit

This block is the execute stage for the arithmetic, logical and compare classes of a 16-bit instruction set. Each accepted request brings two operands, a 4-bit instruction class code, a 4-bit modifier nibble and a 4-bit operation code. One clock later the block presents a 16-bit result. It may also present a write to one of the two condition flags, called A and B.

The modifier nibble is decoded differently for each class. Arithmetic uses it to choose signed or unsigned operation, to request an overflow flag write, to pick the flag and to invert the result. Logical operations use it to request a zero-test flag write, to pick the flag, to invert the flag value and to invert the result. Compares use it to choose signed ordering, to pick the flag and to invert the flag value. Register writeback and predicated execution belong to neighbouring blocks.

Top module: `flag_alu`

## Requirements
- R1: The block accepts a request when `in_valid` is high and `in_class` is 4'b0001 (arithmetic), 4'b0010 (logical) or 4'b0011 (compare). It raises `out_valid` exactly one cycle later. Other class codes, or `in_valid` low, give `out_valid`=0 and `out_flag_we`=0 in the next cycle. Reset clears both outputs.
- R2: Arithmetic op codes are 0 add, 1 subtract, 2 multiply and 3 divide. Modifier bit 3 selects two's-complement signed (1) or unsigned (0) operation. The result is the low 16 bits, and signed division truncates toward zero.
- R3: Arithmetic overflow is defined per operation:
  - Add and subtract: the carry out (add) or borrow (subtract) when unsigned, and two's-complement overflow when signed.
  - Multiply: the full product does not fit in 16 bits of the selected signedness.
- R4: Division by zero returns 16'hFFFF and counts as overflow. Signed 16'h8000 divided by 16'hFFFF returns 16'h8000 and counts as overflow.
- R5: For arithmetic and logical classes, modifier bit 0 set to 1 replaces the result with its bitwise inverse. The arithmetic overflow outcome is not affected by this bit.
- R6: For arithmetic with modifier bit 2 set to 1, the block writes the overflow outcome (1 or 0) to the flag chosen by modifier bit 1 (0 = A, 1 = B). With modifier bit 2 at 0, no flag write occurs.
- R7: Logical op codes are 0 AND, 1 OR and 2 XOR.
- R8: For a logical operation with modifier bit 3 set to 1, the block writes a flag. The flag is chosen by modifier bit 2 (0 = A, 1 = B). The value written is (final result == 0) XOR modifier bit 1, and the zero test sees the result after any inversion.
- R9: Compare op codes in `in_op[1:0]` are 0 equal, 1 less than and 2 greater than. Modifier bit 3 selects signed ordering. The result is the outcome zero-extended to 16 bits. A flag write always occurs, to the flag chosen by modifier bit 2, with value outcome XOR modifier bit 1.
- R10: An op code outside the listed set in an accepted class still gives `out_valid`=1, with result 0 and no flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_class | input | 4 | Instruction class code |
| in_mod | input | 4 | Modifier nibble |
| in_op | input | 4 | Operation code |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Result present |
| out_result | output | 16 | Result word |
| out_flag_we | output | 1 | Condition flag write enable |
| out_flag_sel | output | 1 | Flag index, 0 = A, 1 = B |
| out_flag_val | output | 1 | Value written to the flag |

## Verification
The properties assume that the request inputs are stable only at the sampling edge. They relate each output cycle to the class, modifier and op code of the preceding cycle, so a request may arrive every cycle. They also assume that any value of `in_op[3:2]` may appear in a compare.

The stimulus is applied away from the clock edge. It mixes back-to-back requests with idle cycles and unsupported class codes, and it drives operand pairs chosen to sit exactly on carry, borrow, signed-overflow and divide edge values.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int unsigned DATA_W = 16;

    localparam logic [3:0] CLASS_ARITH = 4'b0001;
    localparam logic [3:0] CLASS_LOGIC = 4'b0010;
    localparam logic [3:0] CLASS_CMP   = 4'b0011;

    typedef enum logic [1:0] {
        UNIT_NONE  = 2'd0,
        UNIT_ARITH = 2'd1,
        UNIT_LOGIC = 2'd2,
        UNIT_CMP   = 2'd3
    } unit_e;

    typedef enum logic [3:0] {
        AR_ADD = 4'd0,
        AR_SUB = 4'd1,
        AR_MUL = 4'd2,
        AR_DIV = 4'd3
    } arith_op_e;

    typedef enum logic [3:0] {
        LG_AND = 4'd0,
        LG_OR  = 4'd1,
        LG_XOR = 4'd2
    } logic_op_e;

    typedef enum logic [1:0] {
        CM_EQ = 2'd0,
        CM_LT = 2'd1,
        CM_GT = 2'd2
    } cmp_op_e;

    typedef struct packed {
        logic we;
        logic sel;
        logic val;
    } flag_wr_t;

    function automatic unit_e class_to_unit(logic [3:0] cls);
        unit_e u;
        case (cls)
            CLASS_ARITH: u = UNIT_ARITH;
            CLASS_LOGIC: u = UNIT_LOGIC;
            CLASS_CMP:   u = UNIT_CMP;
            default:     u = UNIT_NONE;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [3:0]   mods,
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output flag_wr_t     flag
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic sgn, ovf_req, sel, inv;
    assign sgn     = mods[3];
    assign ovf_req = mods[2];
    assign sel     = mods[1];
    assign inv     = mods[0];

    logic [W:0]            sum_u, diff_u;
    logic [2*W-1:0]        prod_u;
    logic signed [2*W-1:0] ext_a, ext_b, prod_s;
    logic [2*W-W:0]        prod_hi_s;
    logic                  div_zero, div_wrap;
    logic [W-1:0]          divisor;
    logic [W-1:0]          quot_u;
    logic signed [W-1:0]   quot_s;

    assign sum_u     = {1'b0, a} + {1'b0, b};
    assign diff_u    = {1'b0, a} - {1'b0, b};
    assign prod_u    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign ext_a     = {{W{a[W-1]}}, a};
    assign ext_b     = {{W{b[W-1]}}, b};
    assign prod_s    = ext_a * ext_b;
    assign prod_hi_s = prod_s[2*W-1:W-1];

    assign div_zero = (b == '0);
    assign div_wrap = sgn && (a == MIN_NEG) && (b == ALL_ONE);
    assign divisor  = (div_zero || div_wrap) ? ONE : b;
    assign quot_u   = a / divisor;
    assign quot_s   = $signed(a) / $signed(divisor);

    logic [W-1:0] raw;
    logic         ovf, known;

    always_comb begin
        raw   = '0;
        ovf   = 1'b0;
        known = 1'b1;
        case (op)
            AR_ADD: begin
                raw = sum_u[W-1:0];
                ovf = sgn ? ((a[W-1] == b[W-1]) && (sum_u[W-1] != a[W-1]))
                          : sum_u[W];
            end
            AR_SUB: begin
                raw = diff_u[W-1:0];
                ovf = sgn ? ((a[W-1] != b[W-1]) && (diff_u[W-1] != a[W-1]))
                          : diff_u[W];
            end
            AR_MUL: begin
                raw = sgn ? prod_s[W-1:0] : prod_u[W-1:0];
                ovf = sgn ? !((&prod_hi_s) || !(|prod_hi_s))
                          : (|prod_u[2*W-1:W]);
            end
            AR_DIV: begin
                if (div_zero) begin
                    raw = ALL_ONE;
                    ovf = 1'b1;
                end else if (sgn) begin
                    raw = quot_s;
                    ovf = div_wrap;
                end else begin
                    raw = quot_u;
                    ovf = 1'b0;
                end
            end
            default: known = 1'b0;
        endcase
    end

    assign result   = known ? (inv ? ~raw : raw) : '0;
    assign flag.we  = known && ovf_req;
    assign flag.sel = sel;
    assign flag.val = ovf;

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [3:0]   mods,
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output flag_wr_t     flag
);
    logic zero_req, sel, flip, inv;
    assign zero_req = mods[3];
    assign sel      = mods[2];
    assign flip     = mods[1];
    assign inv      = mods[0];

    logic [W-1:0] raw, shaped;
    logic         known;

    always_comb begin
        known = 1'b1;
        case (op)
            LG_AND:  raw = a & b;
            LG_OR:   raw = a | b;
            LG_XOR:  raw = a ^ b;
            default: begin
                raw   = '0;
                known = 1'b0;
            end
        endcase
    end

    assign shaped   = inv ? ~raw : raw;
    assign result   = known ? shaped : '0;
    assign flag.we  = known && zero_req;
    assign flag.sel = sel;
    assign flag.val = (shaped == '0) ^ flip;

endmodule

// File: rtl/flag_alu_cmp.sv
module flag_alu_cmp
    import flag_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [3:1]   mods,
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output flag_wr_t     flag
);
    logic sgn, sel, flip;
    assign sgn  = mods[3];
    assign sel  = mods[2];
    assign flip = mods[1];

    logic is_eq, is_lt, is_gt, outcome, known;

    assign is_eq = (a == b);
    assign is_lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    assign is_gt = sgn ? ($signed(a) > $signed(b)) : (a > b);

    always_comb begin
        known = 1'b1;
        case (op)
            CM_EQ:   outcome = is_eq;
            CM_LT:   outcome = is_lt;
            CM_GT:   outcome = is_gt;
            default: begin
                outcome = 1'b0;
                known   = 1'b0;
            end
        endcase
    end

    assign result   = {{(W-1){1'b0}}, outcome};
    assign flag.we  = known;
    assign flag.sel = sel;
    assign flag.val = outcome ^ flip;

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [3:0]   in_class,
    input  logic [3:0]   in_mod,
    input  logic [3:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_flag_we,
    output logic         out_flag_sel,
    output logic         out_flag_val
);
    unit_e        unit;
    logic         accept;
    logic [W-1:0] res_ar, res_lg, res_cm, res_sel;
    flag_wr_t     fl_ar, fl_lg, fl_cm, fl_sel;

    assign unit   = class_to_unit(in_class);
    assign accept = in_valid && (unit != UNIT_NONE);

    flag_alu_arith #(.W(W)) u_arith (
        .mods(in_mod), .op(in_op), .a(in_a), .b(in_b),
        .result(res_ar), .flag(fl_ar)
    );

    flag_alu_logic #(.W(W)) u_logic (
        .mods(in_mod), .op(in_op), .a(in_a), .b(in_b),
        .result(res_lg), .flag(fl_lg)
    );

    flag_alu_cmp #(.W(W)) u_cmp (
        .mods(in_mod[3:1]), .op(in_op[1:0]), .a(in_a), .b(in_b),
        .result(res_cm), .flag(fl_cm)
    );

    always_comb begin
        case (unit)
            UNIT_ARITH: begin res_sel = res_ar; fl_sel = fl_ar; end
            UNIT_LOGIC: begin res_sel = res_lg; fl_sel = fl_lg; end
            UNIT_CMP:   begin res_sel = res_cm; fl_sel = fl_cm; end
            default:    begin res_sel = '0;     fl_sel = '0;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_flag_we  <= 1'b0;
            out_flag_sel <= 1'b0;
            out_flag_val <= 1'b0;
        end else begin
            out_valid    <= accept;
            out_result   <= accept ? res_sel : '0;
            out_flag_we  <= accept && fl_sel.we;
            out_flag_sel <= fl_sel.sel;
            out_flag_val <= fl_sel.val;
        end
    end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [3:0]   in_class,
    input logic [3:0]   in_mod,
    input logic [3:0]   in_op,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic [W-1:0] out_result,
    input logic         out_flag_we,
    input logic         out_flag_sel,
    input logic         out_flag_val
);
    logic cls_ok, is_ar, is_lg, is_cm;
    assign cls_ok = (in_class == CLASS_ARITH) || (in_class == CLASS_LOGIC) ||
                    (in_class == CLASS_CMP);
    assign is_ar  = in_valid && (in_class == CLASS_ARITH);
    assign is_lg  = in_valid && (in_class == CLASS_LOGIC);
    assign is_cm  = in_valid && (in_class == CLASS_CMP);

    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls_ok) |=> out_valid); // R1

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && cls_ok) |=> (!out_valid && !out_flag_we)); // R1

    AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        out_flag_we |-> out_valid); // R1

    AST_DIV_ZERO_ONES: assert property (@(posedge clk) disable iff (rst)
        (is_ar && in_op == 4'd3 && in_b == '0 && !in_mod[0])
        |=> (out_result == {W{1'b1}})); // R4

    AST_DIV_ZERO_OVF: assert property (@(posedge clk) disable iff (rst)
        (is_ar && in_op == 4'd3 && in_b == '0 && in_mod[2])
        |=> (out_flag_we && out_flag_val)); // R4

    AST_NO_ARITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (is_ar && !in_mod[2]) |=> !out_flag_we); // R6

    AST_LOGIC_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (is_lg && in_mod[3] && in_op < 4'd3)
        |=> (out_flag_we && out_flag_sel == $past(in_mod[2]) &&
             out_flag_val == ((out_result == '0) ^ $past(in_mod[1])))); // R8

    AST_CMP_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        (is_cm && in_op[1:0] != 2'd3)
        |=> (out_flag_we && out_result[W-1:1] == '0 &&
             out_flag_val == (out_result[0] ^ $past(in_mod[1])))); // R9

    AST_UNKNOWN_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls_ok && in_op[1:0] == 2'd3 && in_class != CLASS_ARITH)
        |=> (out_result == '0 && !out_flag_we)); // R10

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_mod(in_mod), .in_op(in_op), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result),
    .out_flag_we(out_flag_we), .out_flag_sel(out_flag_sel),
    .out_flag_val(out_flag_val)
);

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;
    localparam time TCK = 8ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_class = '0, in_mod = '0, in_op = '0;
    logic [15:0] in_a = '0, in_b = '0;
    logic        out_valid, out_flag_we, out_flag_sel, out_flag_val;
    logic [15:0] out_result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(TCK/2) clk = ~clk;

    flag_alu u_flag_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_mod(in_mod), .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result),
        .out_flag_we(out_flag_we), .out_flag_sel(out_flag_sel),
        .out_flag_val(out_flag_val)
    );

    typedef struct {
        string       tag;
        logic        v;
        logic [15:0] r;
        logic        we;
        logic        sel;
        logic        val;
    } exp_t;

    exp_t sb_q[$];

    function automatic exp_t model(string tag, logic [3:0] c, logic [3:0] m,
                                   logic [3:0] o, logic [15:0] a, logic [15:0] b);
        exp_t   e;
        longint ua, ub, sa, sb, full, x, y;
        logic   ovf;
        logic   outc;
        logic [15:0] r;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        e.tag = tag; e.v = 1'b1; e.r = '0; e.we = 1'b0; e.sel = 1'b0; e.val = 1'b0;
        if (c == 4'b0001) begin
            x = m[3] ? sa : ua;
            y = m[3] ? sb : ub;
            ovf = 1'b0; r = '0;
            if (o <= 4'd2) begin
                full = (o == 4'd0) ? x + y : (o == 4'd1) ? x - y : x * y;
                r = full[15:0];
                ovf = m[3] ? (full > 32767 || full < -32768) : (full > 65535 || full < 0);
            end else if (o == 4'd3) begin
                if (b == 16'h0) begin
                    r = 16'hFFFF; ovf = 1'b1;
                end else if (m[3] && sa == -32768 && sb == -1) begin
                    r = 16'h8000; ovf = 1'b1;
                end else begin
                    full = x / y; r = full[15:0];
                end
            end
            if (o <= 4'd3) begin
                e.r = m[0] ? ~r : r;
                e.we = m[2]; e.sel = m[1]; e.val = ovf;
            end
        end else if (c == 4'b0010) begin
            if (o <= 4'd2) begin
                r = (o == 4'd0) ? (a & b) : (o == 4'd1) ? (a | b) : (a ^ b);
                if (m[0]) r = ~r;
                e.r = r; e.we = m[3]; e.sel = m[2]; e.val = (r == 16'h0) ^ m[1];
            end
        end else if (c == 4'b0011) begin
            if (o[1:0] != 2'd3) begin
                x = m[3] ? sa : ua;
                y = m[3] ? sb : ub;
                outc = (o[1:0] == 2'd0) ? (x == y) : (o[1:0] == 2'd1) ? (x < y) : (x > y);
                e.r = {15'h0, outc}; e.we = 1'b1; e.sel = m[2]; e.val = outc ^ m[1];
            end
        end else begin
            e.v = 1'b0;
        end
        return e;
    endfunction

    task automatic issue(string tag, logic [3:0] c, logic [3:0] m, logic [3:0] o,
                         logic [15:0] a, logic [15:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_mod = m; in_op = o; in_a = a; in_b = b;
        sb_q.push_back(model(tag, c, m, o, a, b));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_class = 4'b0001; in_mod = 4'b0100; in_op = 4'd3;
            in_a = 16'h1234; in_b = 16'h0;
        end
    endtask

    // monitor: one cycle after each driven request, compare against the queue head
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (out_valid !== e.v ||
                    (e.v && out_result !== e.r) ||
                    out_flag_we !== e.we ||
                    (e.we && (out_flag_sel !== e.sel || out_flag_val !== e.val))) begin
                    bad++;
                    $display("FAIL %s: got v=%b r=%h we=%b sel=%b val=%b, expected v=%b r=%h we=%b sel=%b val=%b",
                             e.tag, out_valid, out_result, out_flag_we, out_flag_sel, out_flag_val,
                             e.v, e.r, e.we, e.sel, e.val);
                end
            end else begin
                total++;
                if (out_valid !== 1'b0 || out_flag_we !== 1'b0) begin
                    bad++;
                    $display("FAIL R1 idle: got v=%b we=%b, expected v=0 we=0",
                             out_valid, out_flag_we);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (out_valid !== 1'b0 || out_flag_we !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got v=%b we=%b, expected v=0 we=0", out_valid, out_flag_we);
        end
        @(negedge clk);
        rst = 1'b0;

        // arithmetic
        issue("R2 add",            4'b0001, 4'b0000, 4'd0, 16'h1234, 16'h1111);
        issue("R3 carry",          4'b0001, 4'b0100, 4'd0, 16'hFFFF, 16'h0002);
        issue("R6 no-ovf B",       4'b0001, 4'b0110, 4'd0, 16'h0003, 16'h0004);
        issue("R3 signed add ovf", 4'b0001, 4'b1100, 4'd0, 16'h7FFF, 16'h0001);
        issue("R3 signed add ok",  4'b0001, 4'b1100, 4'd0, 16'hFFFF, 16'h0001);
        issue("R3 borrow",         4'b0001, 4'b0100, 4'd1, 16'h0001, 16'h0002);
        issue("R3 signed sub ovf", 4'b0001, 4'b1110, 4'd1, 16'h8000, 16'h0001);
        issue("R2 mul wrap",       4'b0001, 4'b0100, 4'd2, 16'h0100, 16'h0100);
        issue("R2 mul small",      4'b0001, 4'b0100, 4'd2, 16'h00FF, 16'h0002);
        issue("R3 smul ok",        4'b0001, 4'b1100, 4'd2, 16'hFFFF, 16'hFFFF);
        issue("R3 umul ovf",       4'b0001, 4'b0100, 4'd2, 16'hFFFF, 16'hFFFF);
        issue("R3 smul edge",      4'b0001, 4'b1110, 4'd2, 16'hFF00, 16'h0080);
        idle(2);
        issue("R2 udiv",           4'b0001, 4'b0100, 4'd3, 16'h0064, 16'h0007);
        issue("R2 sdiv",           4'b0001, 4'b1100, 4'd3, 16'hFF9C, 16'h0007);
        issue("R4 div zero",       4'b0001, 4'b0100, 4'd3, 16'h1234, 16'h0000);
        issue("R4 div zero inv",   4'b0001, 4'b0101, 4'd3, 16'h1234, 16'h0000);
        issue("R4 min by -1",      4'b0001, 4'b1110, 4'd3, 16'h8000, 16'hFFFF);
        issue("R5 inverted add",   4'b0001, 4'b0001, 4'd0, 16'h0001, 16'h0001);
        issue("R5 inv keeps ovf",  4'b0001, 4'b0101, 4'd0, 16'hFFFF, 16'h0001);
        issue("R10 arith op4",     4'b0001, 4'b0111, 4'd4, 16'h5555, 16'h1111);
        // logical
        issue("R7 and",            4'b0010, 4'b0000, 4'd0, 16'hF0F0, 16'h3C3C);
        issue("R7 or",             4'b0010, 4'b0000, 4'd1, 16'hF0F0, 16'h0F00);
        issue("R7 xor",            4'b0010, 4'b0000, 4'd2, 16'hAAAA, 16'h5555);
        issue("R8 zero A",         4'b0010, 4'b1000, 4'd0, 16'h0F0F, 16'hF0F0);
        issue("R8 zero flipped",   4'b0010, 4'b1010, 4'd0, 16'h0F0F, 16'hF0F0);
        issue("R8 nonzero B",      4'b0010, 4'b1100, 4'd1, 16'h0001, 16'h0000);
        issue("R8 inv before test",4'b0010, 4'b1001, 4'd2, 16'hAAAA, 16'h5555);
        issue("R10 logic op3",     4'b0010, 4'b1000, 4'd3, 16'h1234, 16'h4321);
        idle(1);
        // compare
        issue("R9 eq",             4'b0011, 4'b0000, 4'd0, 16'h0005, 16'h0005);
        issue("R9 ult",            4'b0011, 4'b0000, 4'd1, 16'hFFFF, 16'h0001);
        issue("R9 slt",            4'b0011, 4'b1000, 4'd1, 16'hFFFF, 16'h0001);
        issue("R9 sgt flip B",     4'b0011, 4'b1110, 4'd2, 16'h0001, 16'hFFFF);
        issue("R9 ugt B",          4'b0011, 4'b0100, 4'd2, 16'hFFFF, 16'h0001);
        issue("R9 eq false",       4'b0011, 4'b0011, 4'd0, 16'h0005, 16'h0006);
        issue("R10 cmp op3",       4'b0011, 4'b1000, 4'd3, 16'h0005, 16'h0005);
        // rejected class codes
        issue("R1 class 0000",     4'b0000, 4'b0100, 4'd3, 16'h1234, 16'h0000);
        issue("R1 class 0100",     4'b0100, 4'b1000, 4'd0, 16'h0000, 16'h0000);
        idle(4);

        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R1 drain: got %0d pending, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule